// File: doc/BRIEF.md
# Descriptor List Transfer Engine

The engine walks a chain of 16-byte command descriptors held in memory, starting at a command pointer. It reads each descriptor as four 32-bit words over a simple word memory port and decodes a 4-bit opcode from it. A buffer command loads a transfer queue from the descriptor's buffer address and byte count. The queue is handed out in chunks to a peripheral over a request/grant stream port. Each grant carries a start address and a byte count. When a command finishes, the engine writes its residual byte count and the channel status back into the same descriptor, then fetches the next one.

The register unit drives the engine with start, abort and wake pulses and can load the command pointer while the channel is inactive. The engine reports active, dead and wake status bits and exposes the current command pointer. A peripheral that pulls data sees a finished buffer completed only at its next request. A peripheral that pushes data completes the buffer at once, as soon as the buffer is used up.

States: `ST_IDLE` (inactive), `ST_FETCH` (reading the four descriptor words), `ST_DECODE` (classifying the opcode), `ST_READY` (buffer queued, serving requests), `ST_WBACK` (writing completion fields), `ST_HALT` (unsupported buffer command, engine stalled while active). Transitions:
- IDLE→FETCH on start, or on wake when not dead.
- FETCH→DECODE after the fourth word.
- DECODE→READY for a buffer command, DECODE→WBACK for a no-op, DECODE→IDLE for stop or an illegal opcode, DECODE→HALT for an unsupported buffer command.
- READY→WBACK on a request that finds the queue empty, or on a push that drains it.
- WBACK→FETCH when the write is acknowledged.
- HALT→FETCH on wake.
- Any state goes to IDLE on abort and to FETCH on start.

Top module: `cmdlist_engine`

## Requirements
- R1: After reset the active, dead and wake bits are 0, and neither mem_req nor xfer_ack is asserted.
- R2: ptr_load replaces cur_ptr only while the channel is inactive. While active it has no effect.
- R3: A start pulse sets active, clears dead, empties the queue and fetches four words at cur_ptr+0, +4, +8 and +12. The descriptor layout is:
  - word 0 holds the request count in bits [15:0], the option bits in [21:16], the key in [26:24] and the opcode in [31:28];
  - word 1 holds the buffer address;
  - word 3 holds the residual count in bits [15:0] and the status in bits [31:16].
- R4: Opcodes 0 to 3 with key 0 and option bits 0 load the queue with the buffer address and request count, and advance cur_ptr by 16.
- R5: Each grant returns min(requested, remaining) bytes at an address equal to the buffer address plus the bytes already granted. xfer_ack is a single-cycle pulse.
- R6: On completion, a buffer command writes word 3 in full with {status, residual}. The status has active (bit 0) forced to 1 and dead (bit 1) equal to 0, and wake is at bit 2. For a pull, completion happens at the next request that finds the queue empty. That request is then served from the following descriptor.
- R7: A push that drains the queue completes the command and fetches the next descriptor with no further request.
- R8: Opcodes 4, 5 and 6 write only the status half of word 3 (byte strobes 4'b1100), advance cur_ptr by 16 and continue.
- R9: Opcode 7 clears active, writes nothing and leaves cur_ptr unchanged.
- R10: Opcodes 8 to 15 set dead, clear active, write nothing and leave cur_ptr unchanged. Dead never coexists with active.
- R11: A buffer opcode with a non-zero key or non-zero option bits sets up no transfer. cur_ptr stays, active stays 1 and requests get the no-data answer.
- R12: A request while the channel is inactive, dead or stalled is answered with xfer_none=1 and xfer_cnt=0.
- R13: A wake pulse sets the wake bit on the next edge. From idle (not dead) or from a stall it resumes fetching at cur_ptr. Each completed descriptor fetch clears wake.
- R14: An abort pulse returns the engine to idle at once, clears active and dead, drops any pending request and writes nothing back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_pulse | input | 1 | Begin running the list at cur_ptr |
| abort_pulse | input | 1 | Stop at once, no write-back |
| wake_pulse | input | 1 | Set wake and resume an idle or stalled channel |
| ptr_load | input | 1 | Load the command pointer (ignored while active) |
| ptr_value | input | ADDR_W | Pointer value to load |
| cur_ptr | output | ADDR_W | Current command pointer |
| stat_active | output | 1 | Channel active |
| stat_dead | output | 1 | Illegal opcode seen |
| stat_wake | output | 1 | Wake bit |
| mem_req | output | 1 | Memory access request, held until mem_ack |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_wstrb | output | 4 | Byte write strobes |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| xfer_req | input | 1 | Stream chunk request pulse |
| xfer_push | input | 1 | 1 when the peripheral pushes data in, 0 when it pulls |
| xfer_len | input | 16 | Bytes wanted |
| xfer_ack | output | 1 | Grant pulse |
| xfer_none | output | 1 | No data available (with xfer_ack) |
| xfer_cnt | output | 16 | Bytes granted |
| xfer_addr | output | ADDR_W | Start address of the granted bytes |

## Verification
Status bits change on the edge that samples a start, abort or wake pulse, so the bench checks them at the falling edge one cycle later. A grant from a loaded queue comes back two edges after the request edge: one edge latches the request and the next registers the answer. When the request first forces a write-back and a descriptor fetch, the answer is delayed by those memory handshakes, so the bench polls xfer_ack at falling edges with a bounded wait. Chains that finish without a request, such as a push completion or a no-op followed by stop, are checked after polling until active falls. Only then does the bench inspect cur_ptr and the descriptor words in its memory model.

// File: rtl/cmdlist_pkg.sv
package cmdlist_pkg;

    localparam int DESC_BYTES = 16;
    localparam int WORD_BYTES = 4;
    localparam int DESC_WORDS = DESC_BYTES / WORD_BYTES;
    localparam int WIDX_W     = $clog2(DESC_WORDS);
    localparam int CNT_W      = 16;
    localparam int STAT_W     = 16;
    localparam int WB_OFFSET  = 12;

    localparam int ST_BIT_ACTIVE = 0;
    localparam int ST_BIT_DEAD   = 1;
    localparam int ST_BIT_WAKE   = 2;

    localparam logic [3:0] OP_STOP     = 4'd7;
    localparam logic [3:0] OP_NOP_LOW  = 4'd4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_READY,
        ST_WBACK,
        ST_HALT
    } eng_state_t;

    typedef enum logic [2:0] {
        K_BUFFER,
        K_NOP,
        K_STOP,
        K_ILLEGAL,
        K_UNSUP
    } cmd_kind_t;

    function automatic logic [CNT_W-1:0] min_cnt(input logic [CNT_W-1:0] a,
                                                 input logic [CNT_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/cmdlist_desc_buf.sv
module cmdlist_desc_buf #(
    parameter int KEEP_WORDS = 2,
    parameter int IDX_W      = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cap,
    input  logic [IDX_W-1:0]           idx,
    input  logic [31:0]                din,
    output logic [KEEP_WORDS-1:0][31:0] words
);
    for (genvar g = 0; g < KEEP_WORDS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                words[g] <= '0;
            end else if (cap && idx == IDX_W'(g)) begin
                words[g] <= din;
            end
        end
    end
endmodule

// File: rtl/cmdlist_decode.sv
module cmdlist_decode
    import cmdlist_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [31:0]       word0,
    input  logic [31:0]       word1,
    output cmd_kind_t         kind,
    output logic [CNT_W-1:0]  req_cnt,
    output logic [ADDR_W-1:0] buf_addr
);
    logic [3:0] opcode;
    logic [2:0] key;
    logic [5:0] opts;
    logic       unused_bits;

    assign opcode      = word0[31:28];
    assign key         = word0[26:24];
    assign opts        = word0[21:16];
    assign req_cnt     = word0[CNT_W-1:0];
    assign buf_addr    = ADDR_W'(word1);
    assign unused_bits = ^{word0[27], word0[23:22]};

    always_comb begin
        if (opcode > OP_STOP) begin
            kind = K_ILLEGAL;
        end else if (opcode == OP_STOP) begin
            kind = K_STOP;
        end else if (opcode >= OP_NOP_LOW) begin
            kind = K_NOP;
        end else if (key != 3'd0 || opts != 6'd0) begin
            kind = K_UNSUP;
        end else begin
            kind = K_BUFFER;
        end
    end
endmodule

// File: rtl/cmdlist_queue.sv
module cmdlist_queue
    import cmdlist_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [CNT_W-1:0]  load_len,
    input  logic              take,
    input  logic [CNT_W-1:0]  want,
    output logic [CNT_W-1:0]  grant_cnt,
    output logic [ADDR_W-1:0] head_addr,
    output logic [CNT_W-1:0]  remain,
    output logic              empty,
    output logic              drains
);
    logic [CNT_W-1:0]  q_len;
    logic [ADDR_W-1:0] q_addr;

    assign grant_cnt = min_cnt(want, q_len);
    assign head_addr = q_addr;
    assign remain    = q_len;
    assign empty     = (q_len == '0);
    assign drains    = (want >= q_len);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_len  <= '0;
            q_addr <= '0;
        end else if (clear) begin
            q_len  <= '0;
        end else if (load) begin
            q_len  <= load_len;
            q_addr <= load_addr;
        end else if (take) begin
            q_len  <= q_len - grant_cnt;
            q_addr <= q_addr + ADDR_W'(grant_cnt);
        end
    end
endmodule

// File: rtl/cmdlist_engine.sv
module cmdlist_engine
    import cmdlist_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_pulse,
    input  logic              abort_pulse,
    input  logic              wake_pulse,
    input  logic              ptr_load,
    input  logic [ADDR_W-1:0] ptr_value,
    output logic [ADDR_W-1:0] cur_ptr,
    output logic              stat_active,
    output logic              stat_dead,
    output logic              stat_wake,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_wstrb,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack,
    input  logic              xfer_req,
    input  logic              xfer_push,
    input  logic [CNT_W-1:0]  xfer_len,
    output logic              xfer_ack,
    output logic              xfer_none,
    output logic [CNT_W-1:0]  xfer_cnt,
    output logic [ADDR_W-1:0] xfer_addr
);
    localparam int KEEP_WORDS = 2;

    eng_state_t state_q, state_d;

    logic [WIDX_W-1:0]        wcnt;
    logic [ADDR_W-1:0]        ptr_q;
    logic [ADDR_W-1:0]        cur_base;
    logic                     cur_is_buf;
    logic                     active_q, dead_q, wake_q;
    logic                     pend;
    logic                     pend_push;
    logic [CNT_W-1:0]         pend_len;
    logic                     ack_q, none_q;
    logic [CNT_W-1:0]         cnt_q;
    logic [ADDR_W-1:0]        addr_q;

    logic [KEEP_WORDS-1:0][31:0] dwords;
    cmd_kind_t                kind;
    logic [CNT_W-1:0]         dec_cnt;
    logic [ADDR_W-1:0]        dec_addr;

    logic                     last_word;
    logic                     q_load, q_take, q_clear;
    logic [CNT_W-1:0]         g_cnt, q_remain;
    logic [ADDR_W-1:0]        g_addr;
    logic                     q_empty, q_drains;
    logic                     serve_none;
    logic [STAT_W-1:0]        wb_status;

    assign last_word = mem_ack && (wcnt == WIDX_W'(DESC_WORDS - 1));

    cmdlist_desc_buf #(
        .KEEP_WORDS (KEEP_WORDS),
        .IDX_W      (WIDX_W)
    ) u_desc_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (state_q == ST_FETCH && mem_ack),
        .idx   (wcnt),
        .din   (mem_rdata),
        .words (dwords)
    );

    cmdlist_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .word0    (dwords[0]),
        .word1    (dwords[1]),
        .kind     (kind),
        .req_cnt  (dec_cnt),
        .buf_addr (dec_addr)
    );

    assign q_clear = start_pulse || abort_pulse;
    assign q_load  = (state_q == ST_DECODE) && (kind == K_BUFFER);
    assign q_take  = (state_q == ST_READY) && pend && !q_empty && !q_clear;

    cmdlist_queue #(
        .ADDR_W (ADDR_W)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (q_clear),
        .load      (q_load),
        .load_addr (dec_addr),
        .load_len  (dec_cnt),
        .take      (q_take),
        .want      (pend_len),
        .grant_cnt (g_cnt),
        .head_addr (g_addr),
        .remain    (q_remain),
        .empty     (q_empty),
        .drains    (q_drains)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wake_pulse && !dead_q) begin
                    state_d = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (last_word) begin
                    state_d = ST_DECODE;
                end
            end
            ST_DECODE: begin
                unique case (kind)
                    K_BUFFER:  state_d = ST_READY;
                    K_NOP:     state_d = ST_WBACK;
                    K_UNSUP:   state_d = ST_HALT;
                    K_STOP,
                    K_ILLEGAL: state_d = ST_IDLE;
                    default:   state_d = ST_IDLE;
                endcase
            end
            ST_READY: begin
                if (pend && (q_empty || (pend_push && q_drains))) begin
                    state_d = ST_WBACK;
                end
            end
            ST_WBACK: begin
                if (mem_ack) begin
                    state_d = ST_FETCH;
                end
            end
            ST_HALT: begin
                if (wake_pulse) begin
                    state_d = ST_FETCH;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (abort_pulse) begin
            state_d = ST_IDLE;
        end else if (start_pulse) begin
            state_d = ST_FETCH;
        end
    end

    // memory port outputs
    assign wb_status = STAT_W'({wake_q, 1'b0, 1'b1});

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_wstrb = 4'b0000;
        unique case (state_q)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = ptr_q + ADDR_W'({wcnt, 2'b00});
            end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_base + ADDR_W'(WB_OFFSET);
                mem_wdata = {wb_status, q_remain};
                mem_wstrb = cur_is_buf ? 4'b1111 : 4'b1100;
            end
            default: ;
        endcase
    end

    assign serve_none = pend && !ack_q &&
                        (state_q == ST_IDLE || state_q == ST_HALT);

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt       <= '0;
            ptr_q      <= '0;
            cur_base   <= '0;
            cur_is_buf <= 1'b0;
            active_q   <= 1'b0;
            dead_q     <= 1'b0;
            wake_q     <= 1'b0;
            pend       <= 1'b0;
            pend_push  <= 1'b0;
            pend_len   <= '0;
            ack_q      <= 1'b0;
            none_q     <= 1'b0;
            cnt_q      <= '0;
            addr_q     <= '0;
        end else begin
            ack_q <= 1'b0;

            if (state_q == ST_FETCH && mem_ack) begin
                wcnt <= wcnt + 1'b1;
            end

            if (state_q == ST_DECODE) begin
                wake_q <= 1'b0;
                unique case (kind)
                    K_BUFFER, K_NOP: begin
                        ptr_q      <= ptr_q + ADDR_W'(DESC_BYTES);
                        cur_base   <= ptr_q;
                        cur_is_buf <= (kind == K_BUFFER);
                    end
                    K_STOP: active_q <= 1'b0;
                    K_ILLEGAL: begin
                        active_q <= 1'b0;
                        dead_q   <= 1'b1;
                    end
                    default: ;
                endcase
            end

            if (q_take) begin
                ack_q  <= 1'b1;
                none_q <= 1'b0;
                cnt_q  <= g_cnt;
                addr_q <= g_addr;
                pend   <= 1'b0;
            end else if (serve_none) begin
                ack_q  <= 1'b1;
                none_q <= 1'b1;
                cnt_q  <= '0;
                pend   <= 1'b0;
            end else if (xfer_req && !pend && !ack_q) begin
                pend      <= 1'b1;
                pend_push <= xfer_push;
                pend_len  <= xfer_len;
            end

            if (wake_pulse) begin
                wake_q <= 1'b1;
                if ((state_q == ST_IDLE && !dead_q) || state_q == ST_HALT) begin
                    active_q <= 1'b1;
                    wcnt     <= '0;
                end
            end

            if (ptr_load && !active_q) begin
                ptr_q <= ptr_value;
            end

            if (abort_pulse) begin
                active_q <= 1'b0;
                dead_q   <= 1'b0;
                pend     <= 1'b0;
                wcnt     <= '0;
            end else if (start_pulse) begin
                active_q <= 1'b1;
                dead_q   <= 1'b0;
                wcnt     <= '0;
            end
        end
    end

    assign cur_ptr     = ptr_q;
    assign stat_active = active_q;
    assign stat_dead   = dead_q;
    assign stat_wake   = wake_q;
    assign xfer_ack    = ack_q;
    assign xfer_none   = none_q;
    assign xfer_cnt    = cnt_q;
    assign xfer_addr   = addr_q;

endmodule

// File: rtl/cmdlist_engine_chk.sv
module cmdlist_engine_chk
    import cmdlist_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_pulse,
    input logic             abort_pulse,
    input logic             wake_pulse,
    input logic             stat_active,
    input logic             stat_dead,
    input logic             stat_wake,
    input logic             mem_req,
    input logic             mem_we,
    input logic [31:0]      mem_wdata,
    input logic [3:0]       mem_wstrb,
    input logic             xfer_ack,
    input logic             xfer_none,
    input logic [CNT_W-1:0] xfer_cnt
);
    assert_dead_inactive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_dead |-> !stat_active);

    assert_none_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ack && xfer_none) |-> (xfer_cnt == '0));

    assert_start_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_pulse && !abort_pulse) |-> stat_active);

    assert_abort_idle_R14: assert property (@(posedge clk) disable iff (!rst_n)
        $past(abort_pulse) |-> (!stat_active && !stat_dead && !mem_req));

    assert_wb_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[16] && !mem_wdata[17] && mem_wstrb[3:2] == 2'b11));

    assert_ack_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_ack |=> !xfer_ack);

    assert_wake_set_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wake_pulse) |-> stat_wake);
endmodule

bind cmdlist_engine cmdlist_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_pulse (start_pulse),
    .abort_pulse (abort_pulse),
    .wake_pulse  (wake_pulse),
    .stat_active (stat_active),
    .stat_dead   (stat_dead),
    .stat_wake   (stat_wake),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_wdata   (mem_wdata),
    .mem_wstrb   (mem_wstrb),
    .xfer_ack    (xfer_ack),
    .xfer_none   (xfer_none),
    .xfer_cnt    (xfer_cnt)
);

// File: tb/cmdlist_engine_bench.sv
`timescale 1ns/1ps
module cmdlist_engine_bench;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          start_pulse = 0, abort_pulse = 0, wake_pulse = 0;
    logic          ptr_load = 0;
    logic [AW-1:0] ptr_value = '0;
    logic [AW-1:0] cur_ptr;
    logic          stat_active, stat_dead, stat_wake;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata, mem_rdata;
    logic [3:0]    mem_wstrb;
    logic          mem_ack;
    logic          xfer_req = 0, xfer_push = 0;
    logic [15:0]   xfer_len = '0;
    logic          xfer_ack, xfer_none;
    logic [15:0]   xfer_cnt;
    logic [AW-1:0] xfer_addr;

    cmdlist_engine #(.ADDR_W(AW)) u_cmdlist_engine (
        .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse), .abort_pulse(abort_pulse),
        .wake_pulse(wake_pulse), .ptr_load(ptr_load), .ptr_value(ptr_value),
        .cur_ptr(cur_ptr), .stat_active(stat_active), .stat_dead(stat_dead),
        .stat_wake(stat_wake), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .xfer_req(xfer_req), .xfer_push(xfer_push),
        .xfer_len(xfer_len), .xfer_ack(xfer_ack), .xfer_none(xfer_none),
        .xfer_cnt(xfer_cnt), .xfer_addr(xfer_addr)
    );

    // memory model with a host write port
    logic [31:0] mem [0:63];
    logic        h_we = 0;
    logic [5:0]  h_idx = '0;
    logic [31:0] h_data = '0;
    logic        ack_r = 0;
    logic [31:0] rdata_r = '0;
    assign mem_ack   = ack_r;
    assign mem_rdata = rdata_r;

    always @(posedge clk) begin
        ack_r <= 1'b0;
        if (h_we) mem[h_idx] <= h_data;
        if (mem_req && !ack_r) begin
            ack_r   <= 1'b1;
            rdata_r <= mem[mem_addr[7:2]];
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_wstrb[b]) mem[mem_addr[7:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
            end
        end
    end

    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        h_we = 1; h_idx = idx[5:0]; h_data = d;
        @(negedge clk);
        h_we = 0;
    endtask

    function automatic logic [31:0] w0_of(input int op, input int key, input int opts, input int len);
        return {op[3:0], 1'b0, key[2:0], 2'b00, opts[5:0], len[15:0]};
    endfunction

    task automatic put_desc(input int base_idx, input logic [31:0] w0, input logic [31:0] w1,
                            input logic [31:0] w3);
        host_wr(base_idx, w0);
        host_wr(base_idx + 1, w1);
        host_wr(base_idx + 2, 32'h0);
        host_wr(base_idx + 3, w3);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: start_pulse = 1;
            1: abort_pulse = 1;
            default: wake_pulse = 1;
        endcase
        @(negedge clk);
        start_pulse = 0; abort_pulse = 0; wake_pulse = 0;
    endtask

    task automatic load_ptr(input logic [31:0] v);
        @(negedge clk);
        ptr_load = 1; ptr_value = v;
        @(negedge clk);
        ptr_load = 0;
    endtask

    task automatic do_xfer(input int len, input bit push, output int cnt,
                           output logic [31:0] addr, output bit none);
        @(negedge clk);
        xfer_req = 1; xfer_push = push; xfer_len = len[15:0];
        @(negedge clk);
        xfer_req = 0;
        cnt = -1; addr = '0; none = 0;
        for (int i = 0; i < 200; i++) begin
            if (xfer_ack) begin
                cnt = xfer_cnt; addr = xfer_addr; none = xfer_none;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic wait_inactive();
        for (int i = 0; i < 200; i++) begin
            if (!stat_active) break;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    localparam logic [31:0] BUF_A = 32'h0000_4000;
    localparam logic [31:0] W3_INIT = 32'h1234_BEEF;

    task automatic run_case(input int op);
        int len, rem, got, exp_cnt;
        logic [31:0] a;
        bit none;
        bit push;
        len = 5 + 2 * op;
        pulse(1);
        put_desc(0, w0_of(op, 0, 0, len), BUF_A + op, W3_INIT);
        put_desc(4, w0_of(7, 0, 0, 0), 32'h0, 32'h0);
        load_ptr(32'h0);
        pulse(0);
        if (op <= 3) begin
            push = (op >= 2);
            rem = len;
            while (rem > 0) begin
                do_xfer(3, push, got, a, none);
                exp_cnt = (rem < 3) ? rem : 3;
                chk(got == exp_cnt && !none, "R5 grant count", got, exp_cnt);
                chk(a == BUF_A + op + (len - rem), "R5 grant addr", a, BUF_A + op + (len - rem));
                rem -= exp_cnt;
            end
            chk(cur_ptr == 32'h10, "R4 ptr advanced", cur_ptr, 32'h10);
            if (!push) begin
                chk(stat_active, "R6 pull not completed early", stat_active, 1);
                chk(mem[3] == W3_INIT, "R6 no writeback before next pull", mem[3], W3_INIT);
                do_xfer(3, 0, got, a, none);
                chk(none && got == 0, "R6 request after stop answered none", {none, 31'(got)}, 32'h8000_0000);
            end else begin
                wait_inactive();
                chk(!stat_active, "R7 push completion reached stop", stat_active, 0);
            end
            chk(mem[3] == 32'h0001_0000, "R6 writeback word", mem[3], 32'h0001_0000);
        end else if (op <= 6) begin
            wait_inactive();
            chk(mem[3] == 32'h0001_BEEF, "R8 status-only writeback", mem[3], 32'h0001_BEEF);
            chk(cur_ptr == 32'h10, "R8 ptr advanced", cur_ptr, 32'h10);
            chk(!stat_active, "R8 continued to stop", stat_active, 0);
        end else if (op == 7) begin
            wait_inactive();
            chk(!stat_active && !stat_dead, "R9 stop inactive", {stat_active, stat_dead}, 0);
            chk(cur_ptr == 32'h0, "R9 ptr unchanged", cur_ptr, 0);
            chk(mem[3] == W3_INIT, "R9 no writeback", mem[3], W3_INIT);
        end else begin
            wait_inactive();
            chk(stat_dead && !stat_active, "R10 dead set", {stat_active, stat_dead}, 1);
            chk(cur_ptr == 32'h0, "R10 ptr unchanged", cur_ptr, 0);
            chk(mem[3] == W3_INIT, "R10 no writeback", mem[3], W3_INIT);
            do_xfer(4, 0, got, a, none);
            chk(none && got == 0, "R12 dead request none", got, 0);
        end
    endtask

    initial begin
        int got;
        logic [31:0] a;
        bit none;
        repeat (4) @(negedge clk);
        chk(!stat_active && !stat_dead && !stat_wake, "R1 reset status",
            {stat_active, stat_dead, stat_wake}, 0);
        chk(!mem_req && !xfer_ack, "R1 reset idle ports", {mem_req, xfer_ack}, 0);
        rst_n = 1;
        @(negedge clk);
        load_ptr(32'h20);
        chk(cur_ptr == 32'h20, "R2 load while idle", cur_ptr, 32'h20);
        do_xfer(4, 0, got, a, none);
        chk(none && got == 0, "R12 idle request none", got, 0);

        for (int op = 0; op < 16; op++) run_case(op);

        // R13 wake resumes from idle (descriptor 0 is a stop after op 7 rewrite)
        pulse(1);
        put_desc(0, w0_of(7, 0, 0, 0), 32'h0, W3_INIT);
        load_ptr(32'h0);
        @(negedge clk);
        wake_pulse = 1;
        @(negedge clk);
        wake_pulse = 0;
        chk(stat_wake && stat_active, "R13 wake set and resumed", {stat_wake, stat_active}, 3);
        wait_inactive();
        chk(!stat_wake && !stat_active, "R13 wake cleared by fetch", {stat_wake, stat_active}, 0);
        put_desc(0, w0_of(1, 0, 0, 4), BUF_A, W3_INIT);
        pulse(2);
        do_xfer(8, 0, got, a, none);
        chk(got == 4 && !none && a == BUF_A, "R13 resumed buffer served", got, 4);

        // R2 pointer load ignored while active
        load_ptr(32'h80);
        chk(cur_ptr == 32'h10, "R2 load ignored while active", cur_ptr, 32'h10);

        // R14 abort mid-transfer
        pulse(1);
        put_desc(0, w0_of(0, 0, 0, 10), BUF_A, W3_INIT);
        load_ptr(32'h0);
        pulse(0);
        do_xfer(3, 0, got, a, none);
        chk(got == 3, "R5 first chunk", got, 3);
        pulse(1);
        chk(!stat_active && !mem_req, "R14 abort idle", {stat_active, mem_req}, 0);
        repeat (4) @(negedge clk);
        chk(mem[3] == W3_INIT, "R14 no writeback", mem[3], W3_INIT);
        do_xfer(3, 0, got, a, none);
        chk(none, "R14 request after abort none", none, 1);

        // R3 restart clears queue and fetches at advanced pointer (stop at 0x10)
        load_ptr(32'h0);
        pulse(0);
        do_xfer(3, 0, got, a, none);
        chk(got == 3, "R3 chunk before restart", got, 3);
        pulse(0);
        wait_inactive();
        chk(!stat_active && cur_ptr == 32'h10, "R3 restart fetched next", cur_ptr, 32'h10);
        do_xfer(3, 0, got, a, none);
        chk(none, "R3 queue cleared by start", none, 1);
        chk(mem[3] == W3_INIT, "R3 restart wrote nothing", mem[3], W3_INIT);

        // R11 unsupported key, then unsupported option bits
        for (int v = 0; v < 2; v++) begin
            pulse(1);
            put_desc(0, w0_of(0, (v == 0) ? 1 : 0, (v == 0) ? 0 : 6'h01, 8), BUF_A, W3_INIT);
            load_ptr(32'h0);
            pulse(0);
            repeat (20) @(negedge clk);
            chk(stat_active && cur_ptr == 32'h0, "R11 stalled active", {stat_active, cur_ptr[30:0]}, 32'h8000_0000);
            do_xfer(4, 0, got, a, none);
            chk(none && got == 0, "R11 no transfer", got, 0);
            chk(mem[3] == W3_INIT, "R11 no writeback", mem[3], W3_INIT);
        end
        pulse(1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        finished = 1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog act=%h exp=%h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule